// File: doc/BRIEF.md
# Link Speed Retrain Sequencer

This block runs once after reset and decides whether a PCI Express port that trained at the lowest rate should be retrained at a higher one. It first looks at the 5-bit link-training state input. If the link is not in its active state, it ends at once. Otherwise it reads the port's Link Capabilities and Link Status halfwords from the capability structure at configuration offset 0x80. It requests a retrain only when the port supports more than 2.5 GT/s but is running at 2.5 GT/s.

A retrain is a read-modify-write of Link Control that sets the retrain request bit. The block then runs two waits, one after the other. First it polls Link Status until the link-training bit drops. Then it watches the state input until the link is active again. Polls in each wait are separated by a fixed number of idle cycles. Each wait has its own cycle budget. When a budget runs out, the block raises a sticky error flag and moves on.

All configuration traffic uses a simple request/response port with one request outstanding at a time. The configuration transport and the link state machine are outside this block.

Top module: `link_retrain_seq`

## Requirements
- R1: The link counts as up only when `ltssm_state` equals 5'h0F. If it is not up when the sequence starts, the sequencer issues no configuration request and goes straight to completion.
- R2: The first request is a halfword read at byte address 0x08C (capability base 0x80 + 0x0C). If bits 3:0 of the returned data are 1 or less, the sequence completes with no further request.
- R3: The second request is a halfword read at 0x092 (base + 0x12). The sequence continues only when bits 3:0 of the returned data equal 1, the 2.5 GT/s code. Otherwise it completes.
- R4: A retrain is a read of 0x090 (base + 0x10) followed by a write to 0x090. The write data equals the read data with bit 5 set and every other bit unchanged. `link_retrained` goes high after the write completes.
- R5: After the write, the sequencer reads 0x092 repeatedly until bit 11 of the returned data is clear. Between a response and the next read there are exactly POLL_GAP_CYC idle cycles.
- R6: A training poll that returns bit 11 set after at least TRAIN_TMO_CYC cycles in that phase sets the sticky `train_timeout` flag and moves to the link wait. A poll that returns bit 11 clear never raises the flag, even at that moment.
- R7: In the link wait, the state input is checked at phase entry and then every POLL_GAP_CYC+1 cycles. The sequence completes when the link is up.
- R8: A link check that finds the link down after at least LINK_TMO_CYC cycles in that phase sets the sticky `linkup_timeout` flag and completes the sequence.
- R9: `seq_done` is high for exactly one cycle per run, and no request is issued after it.
- R10: A request holds its valid, write, address and data stable until it is accepted. Addresses are halfword aligned, and the next request is issued only after the response.
- R11: While reset is held, `seq_done`, `link_retrained`, both timeout flags and `cfg_req_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the sequence starts when it is released |
| ltssm_state | input | 5 | Current link-training state code |
| cfg_req_valid | output | 1 | Configuration request pending |
| cfg_req_ready | input | 1 | Transport accepts the pending request |
| cfg_req_write | output | 1 | 1 = halfword write, 0 = halfword read |
| cfg_req_addr | output | 12 | Configuration byte address |
| cfg_req_wdata | output | 16 | Write data |
| cfg_rsp_valid | input | 1 | Response to the accepted request |
| cfg_rsp_rdata | input | 16 | Read data of the response |
| seq_done | output | 1 | One-cycle pulse at the end of the sequence |
| link_retrained | output | 1 | A retrain request was written |
| train_timeout | output | 1 | The training-bit wait ran out of cycles |
| linkup_timeout | output | 1 | The link-up wait ran out of cycles |

## Verification
Two events can land on the same poll. The training-bit-clear result can arrive on the very poll at which the training budget has been used up. The bench finds that poll by counting: with a 4-cycle gap and a 20-cycle budget, poll responses arrive 2, 9, 16 and 23 cycles into the phase, so the fourth poll is the first one past the budget. The responder clears bit 11 on exactly that poll, and the bench expects no training timeout after four polls. A companion case never clears the bit and expects the flag after the same four polls, which shows the boundary lies on that poll and not one later.

// File: rtl/lrs_pkg.sv
// Package: shared constants and state encoding for the link retrain sequencer.
// Assumes a halfword-addressed capability structure with the link registers
// at fixed offsets from its base.
package lrs_pkg;

    localparam logic [4:0] LTSSM_ACTIVE = 5'h0F;

    localparam int LINK_CAP_OFS = 12;
    localparam int LINK_CTL_OFS = 16;
    localparam int LINK_STA_OFS = 18;

    localparam int         SPEED_W     = 4;
    localparam logic [3:0] SPEED_2G5   = 4'd1;
    localparam int         RETRAIN_BIT = 5;
    localparam int         TRAINING_BIT = 11;

    typedef enum logic [3:0] {
        ST_CHECK,
        ST_CAP_RD,
        ST_CAP_WT,
        ST_STA_RD,
        ST_STA_WT,
        ST_CTL_RD,
        ST_CTL_WT,
        ST_WR,
        ST_WR_WT,
        ST_TRN_RD,
        ST_TRN_WT,
        ST_TRN_GAP,
        ST_LNK_CHK,
        ST_LNK_GAP,
        ST_FINISH,
        ST_HALT
    } seq_state_e;

endpackage

// File: rtl/lrs_req_port.sv
// Module: single-outstanding configuration request port.
// Latches a request on 'issue', holds it on the bus until accepted, then
// waits for the response and flags it with 'rsp_hit'. Assumes the owner
// issues only when no request is in flight.
module lrs_req_port #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic              issue_we,
    input  logic [ADDR_W-1:0] issue_addr,
    input  logic [DATA_W-1:0] issue_wdata,
    output logic              cfg_req_valid,
    input  logic              cfg_req_ready,
    output logic              cfg_req_write,
    output logic [ADDR_W-1:0] cfg_req_addr,
    output logic [DATA_W-1:0] cfg_req_wdata,
    input  logic              cfg_rsp_valid,
    input  logic [DATA_W-1:0] cfg_rsp_rdata,
    output logic              rsp_hit,
    output logic [DATA_W-1:0] rsp_data
);

    logic waiting;

    // Hold request fields and track the accept/response handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_req_valid <= 1'b0;
            cfg_req_write <= 1'b0;
            cfg_req_addr  <= '0;
            cfg_req_wdata <= '0;
            waiting       <= 1'b0;
        end else if (issue) begin
            cfg_req_valid <= 1'b1;
            cfg_req_write <= issue_we;
            cfg_req_addr  <= issue_addr;
            cfg_req_wdata <= issue_wdata;
        end else if (cfg_req_valid && cfg_req_ready) begin
            cfg_req_valid <= 1'b0;
            waiting       <= 1'b1;
        end else if (waiting && cfg_rsp_valid) begin
            waiting       <= 1'b0;
        end
    end

    // Response is meaningful only while a request is in flight.
    always_comb begin
        rsp_hit  = waiting && cfg_rsp_valid;
        rsp_data = cfg_rsp_rdata;
    end

endmodule

// File: rtl/lrs_wait_timer.sv
// Module: poll spacing and phase budget counters.
// 'phase_clr' zeroes the elapsed-cycle counter at the start of a wait phase;
// it then counts up and saturates. 'gap_load' starts a poll gap of GAP_CYC
// cycles. Assumes GAP_CYC >= 1.
module lrs_wait_timer #(
    parameter int GAP_CYC = 10000,
    parameter int TRN_TMO = 100000000,
    parameter int LNK_TMO = 100000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic phase_clr,
    input  logic gap_load,
    output logic gap_zero,
    output logic trn_expired,
    output logic lnk_expired
);

    localparam int TMO_MAX = (TRN_TMO > LNK_TMO) ? TRN_TMO : LNK_TMO;
    localparam int CW      = $clog2(TMO_MAX + 2);
    localparam int GW      = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;

    logic [CW-1:0] elapsed;
    logic [GW-1:0] gap_cnt;

    // Count cycles spent in the current wait phase, saturating at all-ones.
    always_ff @(posedge clk) begin
        if (!rst_n || phase_clr) begin
            elapsed <= '0;
        end else if (elapsed != '1) begin
            elapsed <= elapsed + 1'b1;
        end
    end

    // Count down the idle gap between two polls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_cnt <= '0;
        end else if (gap_load) begin
            gap_cnt <= GW'(GAP_CYC - 1);
        end else if (gap_cnt != '0) begin
            gap_cnt <= gap_cnt - 1'b1;
        end
    end

    // Budget comparisons and gap end.
    always_comb begin
        gap_zero    = (gap_cnt == '0);
        trn_expired = (elapsed >= CW'(TRN_TMO));
        lnk_expired = (elapsed >= CW'(LNK_TMO));
    end

endmodule

// File: rtl/link_retrain_seq.sv
// Module: link speed retrain sequencer (top).
// Runs once after reset: checks link activity, compares supported and
// current speed, sets the retrain bit by read-modify-write when the link sits
// at 2.5 GT/s below its capability, then waits for training to end and for
// the link to return to its active state, each wait with its own budget.
// Assumes the transport answers every accepted request exactly once.
module link_retrain_seq
    import lrs_pkg::*;
#(
    parameter int          ADDR_W        = 12,
    parameter int          DATA_W        = 16,
    parameter logic [11:0] CAP_BASE      = 12'h080,
    parameter int          POLL_GAP_CYC  = 10000,
    parameter int          TRAIN_TMO_CYC = 100000000,
    parameter int          LINK_TMO_CYC  = 100000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        ltssm_state,
    output logic              cfg_req_valid,
    input  logic              cfg_req_ready,
    output logic              cfg_req_write,
    output logic [ADDR_W-1:0] cfg_req_addr,
    output logic [DATA_W-1:0] cfg_req_wdata,
    input  logic              cfg_rsp_valid,
    input  logic [DATA_W-1:0] cfg_rsp_rdata,
    output logic              seq_done,
    output logic              link_retrained,
    output logic              train_timeout,
    output logic              linkup_timeout
);

    localparam logic [ADDR_W-1:0] A_CAP = ADDR_W'(CAP_BASE) + ADDR_W'(LINK_CAP_OFS);
    localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(CAP_BASE) + ADDR_W'(LINK_CTL_OFS);
    localparam logic [ADDR_W-1:0] A_STA = ADDR_W'(CAP_BASE) + ADDR_W'(LINK_STA_OFS);

    seq_state_e        state, nxt;
    logic              issue, issue_we;
    logic [ADDR_W-1:0] issue_addr;
    logic [DATA_W-1:0] issue_wdata;
    logic              rsp_hit;
    logic [DATA_W-1:0] rsp_data;
    logic              phase_clr, gap_load, gap_zero, trn_expired, lnk_expired;
    logic              set_ret, set_et, set_el, ld_ctl;
    logic [DATA_W-1:0] ctl_shadow;
    logic              link_up;
    logic [SPEED_W-1:0] rsp_speed;

    lrs_req_port #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_port (
        .clk           (clk),
        .rst_n         (rst_n),
        .issue         (issue),
        .issue_we      (issue_we),
        .issue_addr    (issue_addr),
        .issue_wdata   (issue_wdata),
        .cfg_req_valid (cfg_req_valid),
        .cfg_req_ready (cfg_req_ready),
        .cfg_req_write (cfg_req_write),
        .cfg_req_addr  (cfg_req_addr),
        .cfg_req_wdata (cfg_req_wdata),
        .cfg_rsp_valid (cfg_rsp_valid),
        .cfg_rsp_rdata (cfg_rsp_rdata),
        .rsp_hit       (rsp_hit),
        .rsp_data      (rsp_data)
    );

    lrs_wait_timer #(
        .GAP_CYC (POLL_GAP_CYC),
        .TRN_TMO (TRAIN_TMO_CYC),
        .LNK_TMO (LINK_TMO_CYC)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .phase_clr   (phase_clr),
        .gap_load    (gap_load),
        .gap_zero    (gap_zero),
        .trn_expired (trn_expired),
        .lnk_expired (lnk_expired)
    );

    // Decode link activity and the speed field of the current response.
    always_comb begin
        link_up   = (ltssm_state == LTSSM_ACTIVE);
        rsp_speed = rsp_data[SPEED_W-1:0];
    end

    // Next-state and per-state control decode.
    always_comb begin
        nxt         = state;
        issue       = 1'b0;
        issue_we    = 1'b0;
        issue_addr  = A_STA;
        issue_wdata = ctl_shadow;
        phase_clr   = 1'b0;
        gap_load    = 1'b0;
        set_ret     = 1'b0;
        set_et      = 1'b0;
        set_el      = 1'b0;
        ld_ctl      = 1'b0;
        case (state)
            ST_CHECK:   nxt = link_up ? ST_CAP_RD : ST_FINISH;
            ST_CAP_RD: begin
                issue      = 1'b1;
                issue_addr = A_CAP;
                nxt        = ST_CAP_WT;
            end
            ST_CAP_WT: if (rsp_hit) nxt = (rsp_speed > SPEED_2G5) ? ST_STA_RD : ST_FINISH;
            ST_STA_RD: begin
                issue = 1'b1;
                nxt   = ST_STA_WT;
            end
            ST_STA_WT: if (rsp_hit) nxt = (rsp_speed == SPEED_2G5) ? ST_CTL_RD : ST_FINISH;
            ST_CTL_RD: begin
                issue      = 1'b1;
                issue_addr = A_CTL;
                nxt        = ST_CTL_WT;
            end
            ST_CTL_WT: if (rsp_hit) begin
                ld_ctl = 1'b1;
                nxt    = ST_WR;
            end
            ST_WR: begin
                issue                    = 1'b1;
                issue_we                 = 1'b1;
                issue_addr               = A_CTL;
                issue_wdata[RETRAIN_BIT] = 1'b1;
                nxt                      = ST_WR_WT;
            end
            ST_WR_WT: if (rsp_hit) begin
                set_ret   = 1'b1;
                phase_clr = 1'b1;
                nxt       = ST_TRN_RD;
            end
            ST_TRN_RD: begin
                issue = 1'b1;
                nxt   = ST_TRN_WT;
            end
            ST_TRN_WT: if (rsp_hit) begin
                if (!rsp_data[TRAINING_BIT]) begin
                    phase_clr = 1'b1;
                    nxt       = ST_LNK_CHK;
                end else if (trn_expired) begin
                    set_et    = 1'b1;
                    phase_clr = 1'b1;
                    nxt       = ST_LNK_CHK;
                end else begin
                    gap_load = 1'b1;
                    nxt      = ST_TRN_GAP;
                end
            end
            ST_TRN_GAP: if (gap_zero) nxt = ST_TRN_RD;
            ST_LNK_CHK: begin
                if (link_up) begin
                    nxt = ST_FINISH;
                end else if (lnk_expired) begin
                    set_el = 1'b1;
                    nxt    = ST_FINISH;
                end else begin
                    gap_load = 1'b1;
                    nxt      = ST_LNK_GAP;
                end
            end
            ST_LNK_GAP: if (gap_zero) nxt = ST_LNK_CHK;
            ST_FINISH:  nxt = ST_HALT;
            default:    nxt = ST_HALT;
        endcase
    end

    // Sequencer state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_CHECK;
        else        state <= nxt;
    end

    // Keep the Link Control value read for the modify step.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl_shadow <= '0;
        else if (ld_ctl) ctl_shadow <= rsp_data;
    end

    // Sticky result flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_retrained <= 1'b0;
            train_timeout  <= 1'b0;
            linkup_timeout <= 1'b0;
        end else begin
            if (set_ret) link_retrained <= 1'b1;
            if (set_et)  train_timeout  <= 1'b1;
            if (set_el)  linkup_timeout <= 1'b1;
        end
    end

    // Completion pulse: the finish state lasts exactly one cycle.
    always_comb seq_done = (state == ST_FINISH);

endmodule

// File: rtl/lrs_checker.sv
// Module: protocol and result checks for link_retrain_seq, attached by bind.
// Assumes synchronous active-low reset held from time zero.
module lrs_checker #(
    parameter int          ADDR_W   = 12,
    parameter int          DATA_W   = 16,
    parameter logic [11:0] CAP_BASE = 12'h080
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_req_valid,
    input logic              cfg_req_ready,
    input logic              cfg_req_write,
    input logic [ADDR_W-1:0] cfg_req_addr,
    input logic [DATA_W-1:0] cfg_req_wdata,
    input logic              cfg_rsp_valid,
    input logic              seq_done,
    input logic              link_retrained,
    input logic              train_timeout,
    input logic              linkup_timeout
);

    logic seen_done;

    // Remember that the run has completed.
    always_ff @(posedge clk) begin
        if (!rst_n)        seen_done <= 1'b0;
        else if (seq_done) seen_done <= 1'b1;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req_valid && !cfg_req_ready |=> cfg_req_valid && $stable(cfg_req_addr)
            && $stable(cfg_req_write) && $stable(cfg_req_wdata)); // R10
    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req_valid |-> !cfg_req_addr[0]); // R10
    AST_WRITE_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req_valid && cfg_req_write |-> cfg_req_wdata[5]
            && cfg_req_addr == ADDR_W'(CAP_BASE + 12'h010)); // R4
    AST_RETRAIN_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_retrained) |-> $past(cfg_rsp_valid)); // R4
    AST_TRAIN_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        train_timeout |=> train_timeout); // R6
    AST_TRAIN_ERR_NEEDS_RETRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        train_timeout |-> link_retrained); // R6
    AST_LINK_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        linkup_timeout |=> linkup_timeout); // R8
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> !seq_done); // R9
    AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        seen_done |-> !cfg_req_valid && !seq_done); // R9

endmodule

bind link_retrain_seq lrs_checker #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CAP_BASE (CAP_BASE)
) u_lrs_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_req_valid  (cfg_req_valid),
    .cfg_req_ready  (cfg_req_ready),
    .cfg_req_write  (cfg_req_write),
    .cfg_req_addr   (cfg_req_addr),
    .cfg_req_wdata  (cfg_req_wdata),
    .cfg_rsp_valid  (cfg_rsp_valid),
    .seq_done       (seq_done),
    .link_retrained (link_retrained),
    .train_timeout  (train_timeout),
    .linkup_timeout (linkup_timeout)
);

// File: tb/tb_link_retrain_seq.sv
module tb_link_retrain_seq;

    localparam int GAP = 4;
    localparam int TTMO = 20;
    localparam int LTMO = 20;

    typedef struct packed {
        logic       up;
        logic [3:0] cap;
        logic [3:0] cur;
        logic [7:0] clr_at;
        logic [11:0] dly;
        logic       ret;
        logic       et;
        logic       el;
        logic [7:0] reqs;
        logic [7:0] polls;
    } vec_t;

    // up cap cur clr_at dly  ret et el reqs polls
    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 4'd3, 4'd1, 8'd0, 12'd0,    1'b0, 1'b0, 1'b0, 8'd0, 8'd0},
        '{1'b1, 4'd1, 4'd1, 8'd0, 12'd0,    1'b0, 1'b0, 1'b0, 8'd1, 8'd0},
        '{1'b1, 4'd0, 4'd1, 8'd0, 12'd0,    1'b0, 1'b0, 1'b0, 8'd1, 8'd0},
        '{1'b1, 4'd2, 4'd2, 8'd0, 12'd0,    1'b0, 1'b0, 1'b0, 8'd2, 8'd0},
        '{1'b1, 4'd3, 4'd1, 8'd1, 12'd3,    1'b1, 1'b0, 1'b0, 8'd5, 8'd1},
        '{1'b1, 4'd2, 4'd1, 8'd3, 12'd3,    1'b1, 1'b0, 1'b0, 8'd7, 8'd3},
        '{1'b1, 4'd2, 4'd1, 8'd4, 12'd3,    1'b1, 1'b0, 1'b0, 8'd8, 8'd4},
        '{1'b1, 4'd2, 4'd1, 8'd0, 12'd3,    1'b1, 1'b1, 1'b0, 8'd8, 8'd4},
        '{1'b1, 4'd2, 4'd1, 8'd2, 12'd1000, 1'b1, 1'b0, 1'b1, 8'd6, 8'd2},
        '{1'b1, 4'd4, 4'd1, 8'd0, 12'd1000, 1'b1, 1'b1, 1'b1, 8'd8, 8'd4}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  ltssm_state = 5'h0E;
    logic        cfg_req_valid, cfg_req_write;
    logic        cfg_req_ready = 1'b1;
    logic [11:0] cfg_req_addr;
    logic [15:0] cfg_req_wdata;
    logic        cfg_rsp_valid = 1'b0;
    logic [15:0] cfg_rsp_rdata = '0;
    logic        seq_done, link_retrained, train_timeout, linkup_timeout;

    int n_chk = 0;
    int n_bad = 0;

    // responder configuration and observations
    vec_t        cur_v;
    int          stall_n = 0;
    int          stall_c, reqs, polls, done_n, lnk_cnt;
    logic        pend, wr_seen, bad_done_len;
    logic [11:0] rd_a [3];
    logic [11:0] wr_a;
    logic [15:0] wr_d;

    always #5 clk = ~clk;

    link_retrain_seq #(
        .POLL_GAP_CYC  (GAP),
        .TRAIN_TMO_CYC (TTMO),
        .LINK_TMO_CYC  (LTMO)
    ) dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .ltssm_state    (ltssm_state),
        .cfg_req_valid  (cfg_req_valid),
        .cfg_req_ready  (cfg_req_ready),
        .cfg_req_write  (cfg_req_write),
        .cfg_req_addr   (cfg_req_addr),
        .cfg_req_wdata  (cfg_req_wdata),
        .cfg_rsp_valid  (cfg_rsp_valid),
        .cfg_rsp_rdata  (cfg_rsp_rdata),
        .seq_done       (seq_done),
        .link_retrained (link_retrained),
        .train_timeout  (train_timeout),
        .linkup_timeout (linkup_timeout)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Transport model, link model and observation, all away from the active edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            ltssm_state   <= cur_v.up ? 5'h0F : 5'h0E;
            cfg_rsp_valid <= 1'b0;
            cfg_req_ready <= 1'b1;
            pend = 1'b0; stall_c = 0; reqs = 0; polls = 0; done_n = 0;
            lnk_cnt = 0; wr_seen = 1'b0; bad_done_len = 1'b0;
            wr_a = '0; wr_d = '0;
            for (int i = 0; i < 3; i++) rd_a[i] = '0;
        end else begin
            if (seq_done) begin
                done_n++;
            end
            if (lnk_cnt > 0) begin
                lnk_cnt--;
                if (lnk_cnt == 0) ltssm_state <= 5'h0F;
            end
            cfg_rsp_valid <= pend;
            pend = 1'b0;
            if (cfg_req_valid) begin
                if (stall_c < stall_n) begin
                    cfg_req_ready <= 1'b0;
                    stall_c++;
                end else begin
                    cfg_req_ready <= 1'b1;
                    stall_c = 0;
                    pend = 1'b1;
                    if (reqs < 3) rd_a[reqs] = cfg_req_addr;
                    reqs++;
                    if (cfg_req_write) begin
                        wr_seen = 1'b1;
                        wr_a = cfg_req_addr;
                        wr_d = cfg_req_wdata;
                        ltssm_state <= 5'h0B;
                        lnk_cnt = int'(cur_v.dly);
                        cfg_rsp_rdata <= 16'h0000;
                    end else if (cfg_req_addr == 12'h08C) begin
                        cfg_rsp_rdata <= {12'h0A4, cur_v.cap};
                    end else if (cfg_req_addr == 12'h090) begin
                        cfg_rsp_rdata <= 16'h8041;
                    end else begin
                        if (wr_seen) begin
                            polls++;
                            cfg_rsp_rdata <= {4'h0, (cur_v.clr_at == 0 || polls < int'(cur_v.clr_at)),
                                              7'h00, cur_v.cur};
                        end else begin
                            cfg_rsp_rdata <= {12'h000, cur_v.cur};
                        end
                    end
                end
            end else begin
                cfg_req_ready <= 1'b1;
            end
        end
    end

    task automatic run_vec(input vec_t v, input int stall, input string tag);
        bit finished = 0;
        cur_v = v;
        stall_n = stall;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R11: reset state
        check(!seq_done && !link_retrained && !train_timeout && !linkup_timeout
              && !cfg_req_valid, "R11", {tag, " reset outputs"},
              {seq_done, link_retrained, train_timeout, linkup_timeout, cfg_req_valid}, 0);
        rst_n = 1'b1;
        for (int c = 0; c < 5000 && !finished; c++) begin
            @(negedge clk);
            if (done_n > 0) finished = 1;
        end
        check(finished, "R9", {tag, " done reached (watchdog)"}, finished, 1);
        repeat (20) @(negedge clk);
        check(done_n == 1, "R9", {tag, " done pulses"}, done_n, 1);
        check(reqs == int'(v.reqs), v.up ? "R2" : "R1", {tag, " request count"}, reqs, v.reqs);
        check(link_retrained == v.ret, "R4", {tag, " retrained"}, link_retrained, v.ret);
        check(train_timeout == v.et, "R6", {tag, " training timeout"}, train_timeout, v.et);
        check(linkup_timeout == v.el, "R8", {tag, " link timeout"}, linkup_timeout, v.el);
        check(polls == int'(v.polls), "R5", {tag, " training polls"}, polls, v.polls);
        if (v.reqs >= 1) check(rd_a[0] == 12'h08C, "R2", {tag, " first address"}, rd_a[0], 12'h08C);
        if (v.reqs >= 2) check(rd_a[1] == 12'h092, "R3", {tag, " second address"}, rd_a[1], 12'h092);
        if (v.ret) begin
            check(rd_a[2] == 12'h090, "R4", {tag, " control read address"}, rd_a[2], 12'h090);
            check(wr_a == 12'h090, "R4", {tag, " write address"}, wr_a, 12'h090);
            check(wr_d == 16'h8061, "R4", {tag, " write data"}, wr_d, 16'h8061);
            // R7: link ends active in every retrained run
            check(ltssm_state == 5'h0F || v.el, "R7", {tag, " link state at end"}, ltssm_state, 5'h0F);
        end
    endtask

    initial begin
        cur_v = VECS[0];
        // vector table
        for (int i = 0; i < NV; i++) begin
            run_vec(VECS[i], 0, $sformatf("vec%0d", i));
        end
        // R10: backpressure on every request must not change the outcome
        run_vec(VECS[5], 3, "stall3");
        // R6: boundary, training bit clears on the poll where the budget is used up
        run_vec(VECS[6], 0, "boundary");
        // R1: link down code one away from the active code
        run_vec(VECS[0], 2, "down_stall");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Global watchdog: counts as a failed check and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R9 watchdog: actual running expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule